// File: doc/BRIEF.md
# Link Speed and Duplex Negotiation Resolver

This block is the control state machine that settles which speed (10 or 100 Mb/s) and which duplex (half or full) an Ethernet transceiver runs at. Three configuration straps drive it: a negotiation-enable strap, a speed strap and a duplex strap. The receive path reports what it hears on the line through abstract one-cycle indicators. One indicator marks a fast link pulse burst. One marks a normal link pulse. One marks a 100 Mb/s idle pattern. A valid strobe qualifies the link partner's ability word at the end of the page exchange. A link-status input reports whether the link is still present.

When negotiation is enabled, the block asks the transmitter to send fast link pulse bursts and waits for the partner to answer. A partner that negotiates is matched against the local abilities, and the best common mode wins. A partner that does not negotiate is handled by parallel detection, which always yields half duplex. In that case the speed comes from the kind of signal that was heard. When negotiation is disabled, the speed and duplex straps set the operating mode directly. In both cases the straps also form the advertised ability word.

Top module: `linkneg_resolver`

## Requirements
- R1: After a synchronous active-low reset with negotiation enabled, the block requests fast link pulse transmission (`flp_tx_req`=1), is unresolved (`resolved`=0), and reports 10 Mb/s half duplex (`mode_fast`=0, `mode_full`=0).
- R2: `adv_abil` follows the straps combinationally. Bit 0 is 10 half and is always 1. Bit 1 is 10 full and equals `strap_full`. Bit 2 is 100 half and equals `strap_fast`. Bit 3 is 100 full and equals `strap_fast` AND `strap_full`.
- R3: While sending pulse bursts, a normal link pulse indication with no other indicator present resolves the link one clock later at 10 Mb/s half duplex, with `flp_tx_req`=0.
- R4: While sending pulse bursts, a 100 Mb/s idle indication with no burst indication resolves the link one clock later at 100 Mb/s half duplex.
- R5: While sending pulse bursts, a received burst moves the block into negotiation. In negotiation `flp_tx_req` stays 1 and `resolved` stays 0 until `partner_valid` is seen.
- R6: In negotiation, `partner_valid` with a nonzero AND of `adv_abil` and `partner_abil` resolves the link one clock later. It selects the first common mode in this order: 100 full, 100 half, 10 full, 10 half.
- R7: In negotiation, `partner_valid` with no common ability bit leaves the block unresolved and sending bursts.
- R8: When `link_ok` is low while resolved with negotiation enabled, the block returns one clock later to `flp_tx_req`=1, `resolved`=0 and 10 half.
- R9: With `neg_en` low, one clock later the block shows `resolved`=1 and `flp_tx_req`=0, and the mode equals the straps registered one clock earlier. Line indicators have no effect. Raising `neg_en` again returns the block to sending bursts, unresolved.
- R10: When several line indicators arrive together while sending bursts, a burst beats the idle pattern and the idle pattern beats a normal link pulse.
- R11: In negotiation, the normal link pulse and idle indications are ignored. The block stays unresolved and sending bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| neg_en | input | 1 | Negotiation enable strap |
| strap_fast | input | 1 | Speed strap, 1 = 100 Mb/s |
| strap_full | input | 1 | Duplex strap, 1 = full |
| rx_flp | input | 1 | Fast link pulse burst heard |
| rx_nlp | input | 1 | Normal link pulse heard |
| rx_idle100 | input | 1 | 100 Mb/s idle pattern heard |
| partner_valid | input | 1 | Partner ability word valid strobe |
| partner_abil | input | 4 | Partner abilities, same bit layout as adv_abil |
| link_ok | input | 1 | Link present |
| adv_abil | output | 4 | Advertised local abilities |
| mode_fast | output | 1 | Selected speed, 1 = 100 Mb/s |
| mode_full | output | 1 | Selected duplex, 1 = full |
| flp_tx_req | output | 1 | Request to transmit pulse bursts |
| resolved | output | 1 | Link mode settled |

## Verification
The hardest case to reach from the ports is a ability-word mismatch after a real burst exchange. That case needs two conditions at once. The advertised word must have been reshaped by the straps so that its only bits are ones the partner lacks. The block must also already be in negotiation when the partner word arrives. The stimulus gets there in a fixed order. It changes the straps while the link is up, drops `link_ok` together with a burst indication, and then presents a disjoint partner word. A second negotiation immediately afterwards shows that the failed exchange left no stale mode behind.

// File: rtl/linkneg_pkg.sv
// Shared types for the link negotiation resolver.
// Assumes the ability word layout: bit 3 = 100F, bit 2 = 100H, bit 1 = 10F, bit 0 = 10H.
package linkneg_pkg;
    localparam int ABIL_W = 4;
    localparam int IDX_W  = $clog2(ABIL_W);

    typedef logic [ABIL_W-1:0] abil_t;

    typedef enum logic [1:0] {
        ST_FORCE = 2'd0,
        ST_FLP   = 2'd1,
        ST_NEG   = 2'd2,
        ST_LINK  = 2'd3
    } neg_state_t;
endpackage

// File: rtl/linkneg_adv.sv
// Builds the advertised ability word from the speed and duplex straps.
// Assumes 10 half is always supported. The index bits of each position
// encode {fast, full}, so a position is set only when its speed and duplex are allowed.
module linkneg_adv
    import linkneg_pkg::*;
(
    input  logic  strap_fast,
    input  logic  strap_full,
    output abil_t adv
);
    // One bit per mode: the mode is advertised when both its speed and its duplex are allowed.
    for (genvar g = 0; g < ABIL_W; g++) begin : g_bit
        localparam bit NEED_FAST = g[1];
        localparam bit NEED_FULL = g[0];
        assign adv[g] = (strap_fast || !NEED_FAST) && (strap_full || !NEED_FULL);
    end
endmodule

// File: rtl/linkneg_prio.sv
// Picks the best mode shared by the local and partner ability words.
// Assumes a higher bit index is a better mode. The winning index is read as {fast, full}.
module linkneg_prio
    import linkneg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  abil_t local_abil,
    input  abil_t peer_abil,
    output logic  any_common,
    output logic  best_fast,
    output logic  best_full
);
    abil_t            common;
    logic [IDX_W-1:0] best_idx;

    // Intersect the two words and report whether they share any mode.
    always_comb begin
        common     = local_abil & peer_abil;
        any_common = |common;
    end

    // Scan upwards so that the highest common bit is the last one kept.
    always_comb begin
        best_idx = '0;
        for (int i = 0; i < ABIL_W; i++) begin
            if (common[i]) best_idx = IDX_W'(i);
        end
    end

    // Split the winning index into its speed and duplex halves.
    always_comb begin
        best_fast = best_idx[1];
        best_full = best_idx[0];
    end

    // R6
    always @(posedge clk) begin
        if (rst_n && any_common) begin
            prio_pick_chk: assert (common[best_idx] && ((common >> best_idx) == abil_t'(1)))
                else $error("priority pick is not the highest common mode");
        end
    end
endmodule

// File: rtl/linkneg_fsm.sv
// Control state machine: forced mode, sending bursts, negotiating and linked.
// Assumes the line indicators and the partner strobe are already synchronous
// to clk. The match inputs come from the priority resolver.
module linkneg_fsm
    import linkneg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic neg_en,
    input  logic strap_fast,
    input  logic strap_full,
    input  logic rx_flp,
    input  logic rx_nlp,
    input  logic rx_idle100,
    input  logic partner_valid,
    input  logic link_ok,
    input  logic match_any,
    input  logic match_fast,
    input  logic match_full,
    output logic mode_fast,
    output logic mode_full,
    output logic flp_tx_req,
    output logic resolved
);
    neg_state_t cur_st, nxt_st;
    logic       fast_q, full_q, nxt_fast, nxt_full;

    // Next-state and next-mode decision for every state.
    always_comb begin
        nxt_st   = cur_st;
        nxt_fast = fast_q;
        nxt_full = full_q;
        if (!neg_en) begin
            nxt_st   = ST_FORCE;
            nxt_fast = strap_fast;
            nxt_full = strap_full;
        end else begin
            unique case (cur_st)
                ST_FORCE: begin
                    nxt_st   = ST_FLP;
                    nxt_fast = 1'b0;
                    nxt_full = 1'b0;
                end
                ST_FLP: begin
                    if (rx_flp) begin
                        nxt_st = ST_NEG;
                    end else if (rx_idle100) begin
                        nxt_st   = ST_LINK;
                        nxt_fast = 1'b1;
                        nxt_full = 1'b0;
                    end else if (rx_nlp) begin
                        nxt_st   = ST_LINK;
                        nxt_fast = 1'b0;
                        nxt_full = 1'b0;
                    end
                end
                ST_NEG: begin
                    if (partner_valid) begin
                        if (match_any) begin
                            nxt_st   = ST_LINK;
                            nxt_fast = match_fast;
                            nxt_full = match_full;
                        end else begin
                            nxt_st = ST_FLP;
                        end
                    end
                end
                ST_LINK: begin
                    if (!link_ok) begin
                        nxt_st   = ST_FLP;
                        nxt_fast = 1'b0;
                        nxt_full = 1'b0;
                    end
                end
                default: nxt_st = ST_FLP;
            endcase
        end
    end

    // State and mode registers with synchronous reset to sending bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= ST_FLP;
            fast_q <= 1'b0;
            full_q <= 1'b0;
        end else begin
            cur_st <= nxt_st;
            fast_q <= nxt_fast;
            full_q <= nxt_full;
        end
    end

    // Decode the registered state into the status outputs.
    always_comb begin
        mode_fast  = fast_q;
        mode_full  = full_q;
        flp_tx_req = (cur_st == ST_FLP) || (cur_st == ST_NEG);
        resolved   = (cur_st == ST_LINK) || (cur_st == ST_FORCE);
    end

    // R3
    nlp_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && cur_st == ST_FLP && rx_nlp && !rx_flp && !rx_idle100)
        |=> (resolved && !mode_fast && !mode_full))
        else $error("normal link pulse did not give 10 half");

    // R4
    idle_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && cur_st == ST_FLP && rx_idle100 && !rx_flp)
        |=> (resolved && mode_fast && !mode_full))
        else $error("idle pattern did not give 100 half");

    // R7
    nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && cur_st == ST_NEG && partner_valid && !match_any)
        |=> (flp_tx_req && !resolved))
        else $error("mismatch resolved the link");

    // R8
    link_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && cur_st == ST_LINK && !link_ok)
        |=> (flp_tx_req && !resolved && !mode_fast && !mode_full))
        else $error("link loss did not restart negotiation");

    // R9
    forced_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_en |=> (resolved && !flp_tx_req
                     && mode_fast == $past(strap_fast) && mode_full == $past(strap_full)))
        else $error("forced mode does not follow straps");

    // R11
    neg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && cur_st == ST_NEG && !partner_valid) |=> (cur_st == ST_NEG))
        else $error("negotiation left without partner word");
endmodule

// File: rtl/linkneg_resolver.sv
// Top of the link speed and duplex resolver. Ties together the ability
// builder, the common-mode priority resolver and the control state machine.
// Assumes every input is synchronous to clk.
module linkneg_resolver
    import linkneg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                neg_en,
    input  logic                strap_fast,
    input  logic                strap_full,
    input  logic                rx_flp,
    input  logic                rx_nlp,
    input  logic                rx_idle100,
    input  logic                partner_valid,
    input  logic [ABIL_W-1:0]   partner_abil,
    input  logic                link_ok,
    output logic [ABIL_W-1:0]   adv_abil,
    output logic                mode_fast,
    output logic                mode_full,
    output logic                flp_tx_req,
    output logic                resolved
);
    abil_t adv_w;
    logic  m_any, m_fast, m_full;

    linkneg_adv u_adv (
        .strap_fast (strap_fast),
        .strap_full (strap_full),
        .adv        (adv_w)
    );

    linkneg_prio u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_abil (adv_w),
        .peer_abil  (partner_abil),
        .any_common (m_any),
        .best_fast  (m_fast),
        .best_full  (m_full)
    );

    linkneg_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .neg_en        (neg_en),
        .strap_fast    (strap_fast),
        .strap_full    (strap_full),
        .rx_flp        (rx_flp),
        .rx_nlp        (rx_nlp),
        .rx_idle100    (rx_idle100),
        .partner_valid (partner_valid),
        .link_ok       (link_ok),
        .match_any     (m_any),
        .match_fast    (m_fast),
        .match_full    (m_full),
        .mode_fast     (mode_fast),
        .mode_full     (mode_full),
        .flp_tx_req    (flp_tx_req),
        .resolved      (resolved)
    );

    // Present the advertised word at the port.
    always_comb adv_abil = adv_w;
endmodule

// File: tb/linkneg_resolver_bench.sv
module linkneg_resolver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       neg_en = 1'b1, strap_fast = 1'b1, strap_full = 1'b1;
    logic       rx_flp = 1'b0, rx_nlp = 1'b0, rx_idle100 = 1'b0;
    logic       partner_valid = 1'b0, link_ok = 1'b1;
    logic [3:0] partner_abil = 4'd0;
    logic [3:0] adv_abil;
    logic       mode_fast, mode_full, flp_tx_req, resolved;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] adv;
        logic       fast, full, flp, res;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    linkneg_resolver u_linkneg_resolver (
        .clk(clk), .rst_n(rst_n), .neg_en(neg_en),
        .strap_fast(strap_fast), .strap_full(strap_full),
        .rx_flp(rx_flp), .rx_nlp(rx_nlp), .rx_idle100(rx_idle100),
        .partner_valid(partner_valid), .partner_abil(partner_abil),
        .link_ok(link_ok), .adv_abil(adv_abil),
        .mode_fast(mode_fast), .mode_full(mode_full),
        .flp_tx_req(flp_tx_req), .resolved(resolved)
    );

    // Advertised word as written in R2.
    function automatic logic [3:0] adv_of(input logic f, input logic d);
        return {f & d, f, d, 1'b1};
    endfunction

    // Driver: set inputs at the falling edge and queue what the next rising edge must show.
    task automatic step(input logic rn, input logic en, input logic sf, input logic sd,
                        input logic flp_i, input logic nlp_i, input logic idl_i,
                        input logic pv, input logic [3:0] pa, input logic lk,
                        input logic ef, input logic ed, input logic eflp, input logic eres,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rn; neg_en = en; strap_fast = sf; strap_full = sd;
        rx_flp = flp_i; rx_nlp = nlp_i; rx_idle100 = idl_i;
        partner_valid = pv; partner_abil = pa; link_ok = lk;
        e.adv = adv_of(sf, sd); e.fast = ef; e.full = ed; e.flp = eflp; e.res = eres; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each rising edge, compare the ports with the oldest queued item.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (adv_abil !== e.adv || mode_fast !== e.fast || mode_full !== e.full ||
                    flp_tx_req !== e.flp || resolved !== e.res) begin
                    n_bad++;
                    $display("FAIL %s: got adv=%b fast=%b full=%b flp=%b res=%b, exp adv=%b fast=%b full=%b flp=%b res=%b",
                             e.tag, adv_abil, mode_fast, mode_full, flp_tx_req, resolved,
                             e.adv, e.fast, e.full, e.flp, e.res);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        //    rn en sf sd flp nlp idl pv pa     lk   ef ed flp res
        step(0, 1, 1, 1, 0, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R1 reset");
        step(1, 1, 1, 1, 0, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R1 idle after reset");
        step(1, 1, 1, 1, 0, 1, 0, 0, 4'h0, 1,   0, 0, 0, 1, "R3 nlp gives 10H");
        step(1, 1, 1, 1, 0, 0, 0, 0, 4'h0, 1,   0, 0, 0, 1, "R3 link held");
        step(1, 1, 1, 1, 0, 0, 0, 0, 4'h0, 0,   0, 0, 1, 0, "R8 link loss after nlp");
        step(1, 1, 1, 1, 0, 0, 1, 0, 4'h0, 1,   1, 0, 0, 1, "R4 idle gives 100H");
        step(1, 1, 1, 1, 0, 0, 0, 0, 4'h0, 0,   0, 0, 1, 0, "R8 link loss after idle");
        step(1, 1, 1, 1, 0, 1, 1, 0, 4'h0, 1,   1, 0, 0, 1, "R10 idle beats nlp");
        step(1, 1, 1, 1, 0, 0, 0, 0, 4'h0, 0,   0, 0, 1, 0, "R8 link loss");
        step(1, 1, 1, 1, 1, 1, 1, 0, 4'h0, 1,   0, 0, 1, 0, "R10 burst beats others, R5 negotiating");
        step(1, 1, 1, 1, 0, 1, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R11 nlp ignored in negotiation");
        step(1, 1, 1, 1, 0, 0, 1, 0, 4'h0, 1,   0, 0, 1, 0, "R11 idle ignored in negotiation");
        step(1, 1, 1, 1, 0, 0, 0, 1, 4'hF, 1,   1, 1, 0, 1, "R6 full match gives 100F");
        step(1, 1, 0, 1, 0, 0, 0, 0, 4'h0, 1,   1, 1, 0, 1, "R2 straps 10/full while linked");
        step(1, 1, 0, 1, 1, 0, 0, 0, 4'h0, 0,   0, 0, 1, 0, "R8 loss with burst present");
        step(1, 1, 0, 1, 1, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R5 burst enters negotiation");
        step(1, 1, 0, 1, 0, 0, 0, 1, 4'h5, 1,   0, 0, 0, 1, "R6 common 10H only");
        step(1, 1, 1, 0, 0, 0, 0, 0, 4'h0, 0,   0, 0, 1, 0, "R8 loss, R2 straps 100/half");
        step(1, 1, 1, 0, 1, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R5 negotiating again");
        step(1, 1, 1, 0, 0, 0, 0, 1, 4'hA, 1,   0, 0, 1, 0, "R7 disjoint partner word");
        step(1, 1, 1, 0, 0, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R7 still unresolved");
        step(1, 1, 1, 0, 1, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R5 burst after mismatch");
        step(1, 1, 1, 0, 0, 0, 0, 1, 4'hF, 1,   1, 0, 0, 1, "R6 common best is 100H");
        step(1, 1, 1, 1, 0, 0, 0, 1, 4'hB, 1,   1, 0, 0, 1, "R2 adv full set while linked");
        step(1, 0, 0, 1, 0, 0, 0, 0, 4'h0, 1,   0, 1, 0, 1, "R9 forced 10F");
        step(1, 0, 1, 1, 1, 1, 1, 0, 4'h0, 0,   1, 1, 0, 1, "R9 forced 100F, indicators ignored");
        step(1, 0, 1, 0, 0, 1, 0, 0, 4'h0, 0,   1, 0, 0, 1, "R9 forced 100H");
        step(1, 1, 1, 0, 0, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R9 enable back sends bursts");
        step(1, 1, 1, 0, 0, 0, 0, 0, 4'h0, 1,   0, 0, 1, 0, "R1 waiting for partner");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule